// File: doc/BRIEF.md
# Four-Instruction Accumulator Core

A deliberately tiny 8-bit processor that keeps its whole architectural state in an accumulator, a 6-bit program counter and one carry bit. Code and data share a single 64-byte memory. The core reaches that memory through a synchronous port: it drives an address, write data and a write strobe, and read data returns on the cycle after the address.

Every instruction is one byte. A 2-bit operation code sits above a 6-bit absolute address. The four operations are NOR with memory, ADD with memory, store accumulator, and branch when carry is clear. Richer operations are built from sequences of these. Negation is NOR with a zero cell and then ADD of a one cell. A left shift is a store and then an add of the same cell. A compare is a complement and then an add, followed by a carry test.

Top module: `tiny_acc_core`

## Requirements
- R1: Active-low asynchronous reset clears the program counter, accumulator and carry. While reset is held, the core drives address 0 with the write strobe low. The first fetch after release reads address 0.
- R2: Instruction encoding: bits [7:6] are the operation (00 NOR, 01 ADD, 10 STA, 11 JCC) and bits [5:0] are the memory address or branch target.
- R3: NOR sets the accumulator to the bitwise NOR of the accumulator and the addressed byte, and leaves carry unchanged.
- R4: ADD sets the accumulator to the 8-bit sum and carry to the sum's carry-out. Adding 0xFF therefore leaves carry 0 only when the accumulator was 0.
- R5: STA writes the accumulator to the addressed byte and changes neither the accumulator nor carry. STA followed by ADD of the same cell doubles the accumulator.
- R6: JCC with carry 0 continues at the target address. JCC with carry 1 continues at the next address and clears carry.
- R7: Read data is used one cycle after its address. NOR and ADD take two cycles, STA takes two cycles (its write, then a refetch), and JCC takes one cycle. The write strobe is never high on two consecutive cycles.
- R8: The program counter advances by one modulo 64, so execution after address 63 continues at address 0.
- R9: Programs that negate, shift and compare values leave memory exactly as an instruction-level model of R2 to R8 predicts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mem_addr_o | output | 6 | Memory address for fetch, operand read or store |
| mem_wdata_o | output | 8 | Store data (accumulator) |
| mem_we_o | output | 1 | Write strobe |
| mem_rdata_i | input | 8 | Read data for the address of the previous cycle |

## Verification
The assertions check the following on every cycle:
- the register values under reset;
- the 9-bit sum and carry of each ADD;
- carry held across NOR;
- accumulator and carry held across a store;
- no back-to-back writes;
- the program counter step after a fetch;
- the branch address driven for a taken JCC and the carry clear on a JCC that is not taken.

Only the bench scenarios can show these:
- the exact cycle in which each store appears;
- the wrap from address 63 to 0;
- that whole negate, shift and compare programs leave memory as an instruction-level model predicts, on both outcomes of each branch.

// File: rtl/tiny_acc_pkg.sv
package tiny_acc_pkg;
  typedef enum logic [1:0] {
    OP_NOR = 2'b00,
    OP_ADD = 2'b01,
    OP_STA = 2'b10,
    OP_JCC = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_FETCH = 2'b00,
    ST_DEC   = 2'b01,
    ST_EXE   = 2'b10
  } st_e;
endpackage

// File: rtl/tiny_acc_alu.sv
module tiny_acc_alu #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] acc_i,
  input  logic [DATA_W-1:0] opnd_i,
  input  logic              add_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o
);
  logic [DATA_W:0] sum;

  always_comb begin
    sum = {1'b0, acc_i} + {1'b0, opnd_i};
    if (add_i) begin
      res_o   = sum[DATA_W-1:0];
      carry_o = sum[DATA_W];
    end else begin
      res_o   = ~(acc_i | opnd_i);
      carry_o = carry_i;
    end
  end
endmodule

// File: rtl/tiny_acc_ctrl.sv
module tiny_acc_ctrl
  import tiny_acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              carry_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              we_o,
  output logic              acc_ld_o,
  output logic              carry_clr_o,
  output logic              add_o,
  output logic [ADDR_W-1:0] pc_o,
  output logic [1:0]        state_o
);
  localparam int OP_W = 2;

  st_e               st_q, st_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              add_q, add_d;
  logic [ADDR_W-1:0] jmp_a;
  op_e               op;
  logic [ADDR_W-1:0] tgt;

  assign op  = op_e'(rdata_i[DATA_W-1 -: OP_W]);
  assign tgt = rdata_i[ADDR_W-1:0];

  always_comb begin
    st_d        = st_q;
    pc_d        = pc_q;
    add_d       = add_q;
    addr_o      = pc_q;
    we_o        = 1'b0;
    acc_ld_o    = 1'b0;
    carry_clr_o = 1'b0;
    jmp_a       = pc_q;
    unique case (st_q)
      ST_FETCH: begin
        pc_d = pc_q + 1'b1;
        st_d = ST_DEC;
      end
      ST_DEC: begin
        unique case (op)
          OP_NOR, OP_ADD: begin
            addr_o = tgt;
            add_d  = (op == OP_ADD);
            st_d   = ST_EXE;
          end
          OP_STA: begin
            addr_o = tgt;
            we_o   = 1'b1;
            st_d   = ST_FETCH;
          end
          default: begin
            // branch overlaps the next fetch
            if (!carry_i) jmp_a = tgt;
            else          carry_clr_o = 1'b1;
            addr_o = jmp_a;
            pc_d   = jmp_a + 1'b1;
          end
        endcase
      end
      ST_EXE: begin
        acc_ld_o = 1'b1;
        pc_d     = pc_q + 1'b1;
        st_d     = ST_DEC;
      end
      default: st_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_FETCH;
      pc_q  <= '0;
      add_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      pc_q  <= pc_d;
      add_q <= add_d;
    end
  end

  assign add_o   = add_q;
  assign pc_o    = pc_q;
  assign state_o = st_q;
endmodule

// File: rtl/tiny_acc_core.sv
module tiny_acc_core #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  logic [DATA_W-1:0] acc_q, alu_res;
  logic              carry_q, alu_c;
  logic              acc_ld, carry_clr, add_sel;
  logic [ADDR_W-1:0] pc_w;
  logic [1:0]        state_w;

  tiny_acc_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rdata_i    (mem_rdata_i),
    .carry_i    (carry_q),
    .addr_o     (mem_addr_o),
    .we_o       (mem_we_o),
    .acc_ld_o   (acc_ld),
    .carry_clr_o(carry_clr),
    .add_o      (add_sel),
    .pc_o       (pc_w),
    .state_o    (state_w)
  );

  tiny_acc_alu #(.DATA_W(DATA_W)) u_alu (
    .acc_i  (acc_q),
    .opnd_i (mem_rdata_i),
    .add_i  (add_sel),
    .carry_i(carry_q),
    .res_o  (alu_res),
    .carry_o(alu_c)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q   <= '0;
      carry_q <= 1'b0;
    end else begin
      if (acc_ld) begin
        acc_q   <= alu_res;
        carry_q <= alu_c;
      end else if (carry_clr) begin
        carry_q <= 1'b0;
      end
    end
  end

  assign mem_wdata_o = acc_q;
endmodule

// File: rtl/tiny_acc_chk.sv
module tiny_acc_chk
  import tiny_acc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        state_w,
  input logic [ADDR_W-1:0] pc_w,
  input logic [DATA_W-1:0] acc_q,
  input logic              carry_q,
  input logic              add_sel,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_rdata_i
);
  logic in_dec, is_jcc;
  assign in_dec = (state_w == ST_DEC);
  assign is_jcc = (mem_rdata_i[DATA_W-1 -: 2] == 2'b11);

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) begin
      reset_state_chk: assert (pc_w == '0 && acc_q == '0 && !carry_q && !mem_we_o);
    end
  end

  // R4
  add_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_EXE && add_sel) |=>
      ({carry_q, acc_q} == ((DATA_W+1)'($past(acc_q)) + (DATA_W+1)'($past(mem_rdata_i)))));

  // R3
  nor_carry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_EXE && !add_sel) |=> $stable(carry_q));

  // R5
  store_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> ($stable(acc_q) && $stable(carry_q)));

  // R7
  single_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  // R8
  pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_w == ST_FETCH) |=> (pc_w == ADDR_W'($past(pc_w) + 1'b1)));

  // R6
  jcc_taken_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_dec && is_jcc && !carry_q) |-> (mem_addr_o == mem_rdata_i[ADDR_W-1:0]));

  // R6
  jcc_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_dec && is_jcc && carry_q) |=> !carry_q);
endmodule

bind tiny_acc_core tiny_acc_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .state_w    (state_w),
  .pc_w       (pc_w),
  .acc_q      (acc_q),
  .carry_q    (carry_q),
  .add_sel    (add_sel),
  .mem_we_o   (mem_we_o),
  .mem_addr_o (mem_addr_o),
  .mem_rdata_i(mem_rdata_i)
);

// File: tb/tiny_acc_core_tb.sv
module tiny_acc_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] addr;
  logic [7:0] wdata, rdata;
  logic       we;
  logic [7:0] mem [64];
  logic [7:0] ref_mem [64];
  int         total = 0;
  int         bad = 0;
  int         cyc = 0;

  localparam logic [1:0] NOR = 2'b00, ADD = 2'b01, STA = 2'b10, JCC = 2'b11;
  localparam int ZERO = 21, ONE = 22, ALL1 = 23;

  always #5ns clk = ~clk;

  tiny_acc_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .mem_addr_o(addr),
    .mem_wdata_o(wdata), .mem_we_o(we), .mem_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    rdata <= mem[addr];
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected<150000 cycles", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] ins(logic [1:0] op, int a);
    return {op, 6'(a)};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'h77;
    mem[ZERO] = 8'h00; mem[ONE] = 8'h01; mem[ALL1] = 8'hFF;
  endtask

  // R1: reset, check idle bus, release at a falling edge
  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 reset addr", 32'(addr), 0);
    chk("R1 reset we", 32'(we), 0);
    for (int i = 0; i < 64; i++) ref_mem[i] = mem[i];
    rst_n = 1'b1;
  endtask

  // instruction-level model of R2..R8
  task automatic ref_run(int steps);
    logic [7:0] acc = 0;
    logic [5:0] pc = 0;
    logic       c = 0;
    logic [7:0] iw;
    for (int s = 0; s < steps; s++) begin
      iw = ref_mem[pc];
      pc = pc + 1'b1;
      case (iw[7:6])
        NOR: acc = ~(acc | ref_mem[iw[5:0]]);
        ADD: {c, acc} = {1'b0, acc} + {1'b0, ref_mem[iw[5:0]]};
        STA: ref_mem[iw[5:0]] = acc;
        default: if (!c) pc = iw[5:0]; else c = 1'b0;
      endcase
    end
  endtask

  task automatic run_and_compare(string req);
    int first = -1;
    repeat (150) @(negedge clk);
    ref_run(200);
    for (int i = 0; i < 64; i++)
      if (first < 0 && mem[i] !== ref_mem[i]) first = i;
    total++;
    if (first >= 0) begin
      bad++;
      $display("FAIL %s model: mem[%0d] actual=%0h expected=%0h", req, first, mem[first], ref_mem[first]);
    end
  endtask

  // R7 R3 R4 R5: store lands in cycle 5 after NOR/ADD of two cycles each
  task automatic t_timing_alu();
    clear_mem();
    mem[0] = ins(NOR, ALL1); mem[1] = ins(ADD, ONE);
    mem[2] = ins(STA, 30);   mem[3] = ins(JCC, 3);
    do_reset();
    for (int k = 0; k < 5; k++) begin
      chk("R7 no early write", 32'(we), 0);
      @(negedge clk);
    end
    chk("R7 store cycle we", 32'(we), 1);
    chk("R7 store addr", 32'(addr), 30);
    chk("R5 store data", 32'(wdata), 8'h01);
    run_and_compare("R7");
  endtask

  // R6 R7: taken branch is one cycle, target driven at once
  task automatic t_timing_jcc();
    clear_mem();
    mem[0] = ins(JCC, 2); mem[2] = ins(STA, 31); mem[3] = ins(JCC, 3);
    do_reset();
    chk("R1 first fetch addr", 32'(addr), 0);
    @(negedge clk);
    chk("R6 jump target addr", 32'(addr), 2);
    @(negedge clk);
    chk("R7 jcc one cycle store we", 32'(we), 1);
    chk("R7 jcc store addr", 32'(addr), 31);
    run_and_compare("R6");
    chk("R5 stored zero acc", 32'(mem[31]), 0);
  endtask

  // R8: fetch after address 63 is address 0
  task automatic t_wrap();
    clear_mem();
    mem[0] = ins(JCC, 62); mem[62] = ins(ADD, 60); mem[63] = ins(STA, 59);
    mem[60] = 8'h05;
    do_reset();
    repeat (4) @(negedge clk);
    chk("R8 store before wrap", 32'(addr), 59);
    chk("R8 store data", 32'(wdata), 5);
    @(negedge clk);
    chk("R8 wrap fetch addr", 32'(addr), 0);
  endtask

  // R9 R3 R4 R5 R6: negate, double, fall-through
  task automatic t_negate();
    clear_mem();
    mem[20] = 8'h2D;
    mem[0] = ins(NOR, ALL1); mem[1] = ins(ADD, 20); mem[2] = ins(NOR, ZERO);
    mem[3] = ins(ADD, ONE);  mem[4] = ins(STA, 24); mem[5] = ins(STA, 25);
    mem[6] = ins(ADD, 25);   mem[7] = ins(STA, 26); mem[8] = ins(JCC, 8);
    mem[9] = ins(JCC, 9);
    do_reset();
    run_and_compare("R9 negate");
    chk("R9 negated value", 32'(mem[24]), 8'hD3);
    chk("R5 store copy", 32'(mem[25]), 8'hD3);
    chk("R5 doubled", 32'(mem[26]), 8'hA6);
  endtask

  // R9 R6: compare both outcomes
  task automatic t_compare(logic [7:0] a, logic [7:0] t, logic [7:0] e24, logic [7:0] e25, logic [7:0] e26);
    clear_mem();
    mem[20] = a; mem[27] = t;
    mem[0] = ins(NOR, ALL1); mem[1] = ins(ADD, 20); mem[2] = ins(NOR, ZERO);
    mem[3] = ins(ADD, 27);   mem[4] = ins(STA, 24); mem[5] = ins(JCC, 8);
    mem[6] = ins(STA, 25);   mem[7] = ins(JCC, 7);  mem[8] = ins(ADD, ONE);
    mem[9] = ins(STA, 26);   mem[10] = ins(JCC, 10);
    do_reset();
    run_and_compare("R9 compare");
    chk("R9 compare diff", 32'(mem[24]), 32'(e24));
    chk("R6 fall path cell", 32'(mem[25]), 32'(e25));
    chk("R6 taken path cell", 32'(mem[26]), 32'(e26));
  endtask

  // R4 R3: add 0xFF zero test, carry survives NOR
  task automatic t_add_ff();
    clear_mem();
    mem[0] = ins(ADD, ALL1); mem[1] = ins(STA, 24); mem[2] = ins(JCC, 4);
    mem[3] = ins(STA, 25);   mem[4] = ins(ADD, ALL1); mem[5] = ins(STA, 26);
    mem[6] = ins(NOR, ZERO); mem[7] = ins(JCC, 9);  mem[8] = ins(STA, 27);
    mem[9] = ins(JCC, 9);
    do_reset();
    run_and_compare("R4");
    chk("R4 zero plus ff", 32'(mem[24]), 8'hFF);
    chk("R4 carry clear when acc was zero", 32'(mem[25]), 8'h77);
    chk("R4 ff plus ff", 32'(mem[26]), 8'hFE);
    chk("R3 nor keeps carry", 32'(mem[27]), 8'h01);
  endtask

  initial begin
    clear_mem();
    t_timing_alu();
    t_timing_jcc();
    t_wrap();
    t_negate();
    t_compare(8'h40, 8'h30, 8'hEF, 8'h77, 8'hF0);
    t_compare(8'h20, 8'h30, 8'h0F, 8'h0F, 8'h77);
    t_add_ff();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule